// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bit-level slave of a two-wire open-drain serial bus. A fast system clock samples both bus lines. The block finds start and stop conditions and collects an eight-bit slave address. The address must carry a fixed four-bit type code followed by the value on four strap inputs. The block then pulls the data line low in the acknowledge slot. After that it receives or sends whole bytes, most significant bit first. Received bytes and framing events go to a command layer as one-cycle strobes. The command layer chooses the direction of each data byte and supplies the bytes to send.

A busy input lets the command layer refuse the address acknowledge while a slow internal write is in progress. The master then polls: it issues a fresh start and the address until an acknowledge comes back. The data line output is a pull-down enable. When that enable is low, the line is released and reads high.

Top module: `twowire_slave_fe`

## Requirements
- R1: A falling edge of the synchronised data line while the synchronised clock line is high is a start. It raises `start_o` for one cycle and begins reception of an address byte.
- R2: A rising edge of the data line while the clock line is high is a stop. It raises `stop_o` for one cycle, releases the data line and returns the slave to idle.
- R3: When the eight address bits, sampled on clock rising edges with the first bit as bit 7, equal binary 0101 in bits 7..4 and `strap_i` in bits 3..0, the slave holds `sda_oe` high from the clock fall after the eighth bit until the fall of the ninth clock. The data line changes only while the clock line is low.
- R4: On an address mismatch the slave gives no acknowledge. It then ignores every byte that follows, with no acknowledge and no `rx_valid_o`, until the next start.
- R5: If `busy_i` is high in the cycle in which the eighth address bit is taken, the address is not acknowledged. Its value in any other cycle has no effect on that acknowledge.
- R6: After an acknowledged address, a byte received while `tx_en_i` was low at the end of the previous acknowledge slot is shifted in MSB first. It is presented on `rx_byte_o` with a one-cycle `rx_valid_o` pulse and is acknowledged.
- R7: If `tx_en_i` is high at the fall that ends an acknowledge slot, the slave loads `tx_byte_i` and pulses `tx_load_o`. It drives the byte MSB first, one bit per clock low phase, and releases the line for the ninth clock.
- R8: In the ninth clock of a sent byte, a low line (master acknowledge) makes the slave load and send the next `tx_byte_i`. A high line makes it release the bus and go idle until a start.
- R9: A start seen in any state aborts the transfer in progress and restarts address reception. A partly received byte is discarded.
- R10: After reset, clock and data activity with no start condition produces no acknowledge and no received byte.
- R11: In reset and just after it, `sda_oe`, `start_o`, `stop_o`, `rx_valid_o` and `tx_load_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 4 | Device address straps, bit 3 most significant |
| busy_i | input | 1 | Withholds the address acknowledge while high |
| tx_en_i | input | 1 | Next data byte is sent by the slave |
| tx_byte_i | input | 8 | Byte to send |
| tx_load_o | output | 1 | One-cycle pulse when `tx_byte_i` is taken |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle pulse with a new received byte |
| start_o | output | 1 | One-cycle pulse on a start condition |
| stop_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
Two events can land in the same system cycle: the busy input changing, and the decision on the eighth address bit. The bench times `busy_i` against the synchronised rise of the eighth clock. It releases busy exactly one cycle before the decision, raises it for that cycle alone, and raises it one cycle too late. The expected results are acknowledge, no acknowledge and acknowledge. This shows that only the value present in the deciding cycle counts.

// File: rtl/tw_fe_pkg.sv
package tw_fe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } fe_state_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-2:0], line_i};
  end

  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det,
  output logic start_o,
  output logic stop_o
);
  always_comb begin
    start_det = scl_lvl & sda_fall;
    stop_det  = scl_lvl & sda_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= start_det;
      stop_o  <= stop_det;
    end
  end
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import tw_fe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     sda_lvl,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [BYTE_W-TYPE_W-1:0] strap,
  input  logic                     busy,
  input  logic                     tx_en,
  input  logic [BYTE_W-1:0]        tx_byte,
  output logic                     sda_oe,
  output logic                     tx_load,
  output logic [BYTE_W-1:0]        rx_byte,
  output logic                     rx_valid,
  output logic                     idle
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fe_state_t          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic [BYTE_W-1:0]  rxb_q;
  logic               drv_q, drv_d;
  logic               mack_q, mack_d;
  logic               rxv_q, rxv_d;
  logic               ld_q, ld_d;
  logic               sh_en, tx_en_reg;
  logic [BYTE_W-1:0]  rx_full;

  assign rx_full = {sh_q[BYTE_W-2:0], sda_lvl};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    drv_d     = drv_q;
    mack_d    = mack_q;
    rxv_d     = 1'b0;
    ld_d      = 1'b0;
    sh_en     = 1'b0;
    tx_en_reg = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      drv_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_en = 1'b1;
          sh_d  = rx_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (rx_full == {DEV_TYPE, strap} && !busy) state_d = ST_ACK;
            else                                       state_d = ST_IDLE;
          end
        end
        ST_RX: if (scl_rise) begin
          sh_en = 1'b1;
          sh_d  = rx_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d   = '0;
            rxv_d   = 1'b1;
            state_d = ST_ACK;
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!drv_q) begin
            drv_d = 1'b1;
          end else begin
            drv_d = 1'b0;
            cnt_d = '0;
            if (tx_en) begin
              state_d   = ST_TX;
              tx_en_reg = 1'b1;
              tx_d      = tx_byte;
              ld_d      = 1'b1;
            end else begin
              state_d = ST_RX;
            end
          end
        end
        ST_TX: if (scl_fall) begin
          tx_en_reg = 1'b1;
          tx_d      = {tx_q[BYTE_W-2:0], 1'b0};
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d   = '0;
            state_d = ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = !sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              state_d   = ST_TX;
              tx_en_reg = 1'b1;
              tx_d      = tx_byte;
              ld_d      = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rxb_q   <= '0;
      drv_q   <= 1'b0;
      mack_q  <= 1'b0;
      rxv_q   <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drv_q   <= drv_d;
      mack_q  <= mack_d;
      rxv_q   <= rxv_d;
      ld_q    <= ld_d;
      if (sh_en)     sh_q  <= sh_d;
      if (tx_en_reg) tx_q  <= tx_d;
      if (rxv_d)     rxb_q <= rx_full;
    end
  end

  assign sda_oe   = (state_q == ST_ACK && drv_q) ||
                    (state_q == ST_TX && !tx_q[BYTE_W-1]);
  assign tx_load  = ld_q;
  assign rx_byte  = rxb_q;
  assign rx_valid = rxv_q;
  assign idle     = (state_q == ST_IDLE);
endmodule

// File: rtl/twowire_slave_fe.sv
module twowire_slave_fe #(
  parameter int BYTE_W      = 8,
  parameter int TYPE_W      = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic [BYTE_W-TYPE_W-1:0] strap_i,
  input  logic                     busy_i,
  input  logic                     tx_en_i,
  input  logic [BYTE_W-1:0]        tx_byte_i,
  output logic                     tx_load_o,
  output logic [BYTE_W-1:0]        rx_byte_o,
  output logic                     rx_valid_o,
  output logic                     start_o,
  output logic                     stop_o
);
  logic rst_meta, rst_ns;
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic bus_idle;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  tw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_ns), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  tw_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_ns), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  tw_cond_detect u_cond (
    .clk(clk), .rst_n(rst_ns), .scl_lvl(scl_lvl),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_det(start_det), .stop_det(stop_det),
    .start_o(start_o), .stop_o(stop_o));

  tw_byte_engine #(.BYTE_W(BYTE_W), .TYPE_W(TYPE_W), .DEV_TYPE(DEV_TYPE)) u_engine (
    .clk(clk), .rst_n(rst_ns),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .busy(busy_i), .tx_en(tx_en_i), .tx_byte(tx_byte_i),
    .sda_oe(sda_oe), .tx_load(tx_load_o), .rx_byte(rx_byte_o),
    .rx_valid(rx_valid_o), .idle(bus_idle));
endmodule

// File: rtl/tw_fe_checker.sv
module tw_fe_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_sync,
  input logic bus_idle,
  input logic rx_valid_o,
  input logic start_o,
  input logic stop_o
);
  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_sync);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!sda_oe && bus_idle));

  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (!sda_oe && !bus_idle));

  assert_cond_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_in_session_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !bus_idle);
endmodule

bind twowire_slave_fe tw_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_sync(scl_lvl),
  .bus_idle(bus_idle), .rx_valid_o(rx_valid_o),
  .start_o(start_o), .stop_o(stop_o));

// File: tb/twowire_slave_fe_test.sv
module twowire_slave_fe_test;
  localparam int H = 8;
  localparam int NV = 7;
  // {addr[13:6], strap[5:2], busy[1], expect_ack[0]}
  localparam logic [13:0] VECS [NV] = '{
    {8'h5A, 4'hA, 1'b0, 1'b1},
    {8'h5A, 4'hB, 1'b0, 1'b0},
    {8'h4A, 4'hA, 1'b0, 1'b0},
    {8'h5F, 4'hF, 1'b0, 1'b1},
    {8'h50, 4'h0, 1'b0, 1'b1},
    {8'h53, 4'h3, 1'b1, 1'b0},
    {8'hDA, 4'hA, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap_i = 4'hA;
  logic busy_i = 1'b0, tx_en_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic sda_oe, tx_load_o, rx_valid_o, start_o, stop_o;
  logic [7:0] rx_byte_o;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_rx = 0, n_load = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twowire_slave_fe uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap_i), .busy_i(busy_i), .tx_en_i(tx_en_i), .tx_byte_i(tx_byte_i),
    .tx_load_o(tx_load_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .start_o(start_o), .stop_o(stop_o));

  always @(negedge clk) begin
    if (start_o) n_start++;
    if (stop_o) n_stop++;
    if (tx_load_o) n_load++;
    if (rx_valid_o) begin n_rx++; last_rx = rx_byte_o; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic clock_bit(input logic b, input int set_k, input int clr_k);
    sda_m = b; wait_n(H);
    scl_m = 1'b1;
    for (int k = 1; k <= H; k++) begin
      @(negedge clk);
      if (k == set_k) busy_i = 1'b1;
      if (k == clr_k) busy_i = 1'b0;
    end
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic ack_slot(output bit ack);
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H/2);
    ack = ~sda_line; wait_n(H/2);
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic send_byte(input logic [7:0] v, input int set_k, input int clr_k, output bit ack);
    for (int i = 7; i >= 0; i--)
      clock_bit(v[i], (i == 0) ? set_k : 0, (i == 0) ? clr_k : 0);
    ack_slot(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack, output logic line9);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_n(H);
      scl_m = 1'b1; wait_n(H/2);
      v[i] = sda_line; wait_n(H/2);
      scl_m = 1'b0; wait_n(4);
    end
    sda_m = ~mack; wait_n(H);
    scl_m = 1'b1; wait_n(H/2);
    line9 = sda_line; wait_n(H/2);
    scl_m = 1'b0; wait_n(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic l9;
    int s0, p0, r0, ld0;
    wait_n(5);
    // R11: reset state
    check(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
    rst_n = 1'b1; wait_n(6);
    check(sda_oe == 1'b0 && tx_load_o == 1'b0 && rx_valid_o == 1'b0, "R11 oe after reset", sda_oe, 0);
    check(start_o == 1'b0 && stop_o == 1'b0, "R11 pulses after reset", {start_o, stop_o}, 0);

    // R10: matching address clocked with no start
    scl_m = 1'b0; wait_n(H);
    send_byte(8'h5A, 0, 0, ack);
    check(ack == 1'b0, "R10 no ack without start", ack, 0);
    send_byte(8'h33, 0, 0, ack);
    check(n_rx == 0, "R10 no byte without start", n_rx, 0);
    scl_m = 1'b1; wait_n(H);

    // vector table: R3 match, R4 mismatch, R5 busy
    s0 = n_start; p0 = n_stop;
    for (int i = 0; i < NV; i++) begin
      strap_i = VECS[i][5:2];
      busy_i  = VECS[i][1];
      bus_start();
      send_byte(VECS[i][13:6], 0, 0, ack);
      check(ack == VECS[i][0], VECS[i][1] ? "R5 busy address" : "R3 address compare", ack, VECS[i][0]);
      bus_stop();
      busy_i = 1'b0;
    end
    check(n_start - s0 == NV, "R1 start pulses", n_start - s0, NV);
    check(n_stop - p0 == NV, "R2 stop pulses", n_stop - p0, NV);
    check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

    // R6: two received bytes
    strap_i = 4'hA; r0 = n_rx;
    bus_start();
    send_byte(8'h5A, 0, 0, ack);
    send_byte(8'hA5, 0, 0, ack);
    check(ack == 1'b1 && last_rx == 8'hA5, "R6 command byte", last_rx, 8'hA5);
    send_byte(8'h3C, 0, 0, ack);
    check(ack == 1'b1 && last_rx == 8'h3C, "R6 data byte", last_rx, 8'h3C);
    check(n_rx - r0 == 2, "R6 strobe count", n_rx - r0, 2);
    bus_stop();

    // R4: mismatch then data ignored
    r0 = n_rx;
    bus_start();
    send_byte(8'h5B, 0, 0, ack);
    send_byte(8'h00, 0, 0, ack);
    check(ack == 1'b0, "R4 no data ack after mismatch", ack, 0);
    check(n_rx == r0, "R4 no strobe after mismatch", n_rx - r0, 0);
    bus_stop();

    // R7/R8: two bytes sent by the slave
    tx_en_i = 1'b1; tx_byte_i = 8'hC6; ld0 = n_load;
    bus_start();
    send_byte(8'h5A, 0, 0, ack);
    tx_byte_i = 8'h39;
    check(n_load - ld0 == 1, "R7 load strobe", n_load - ld0, 1);
    recv_byte(d, 1'b1, l9);
    check(d == 8'hC6, "R7 first sent byte", d, 8'hC6);
    recv_byte(d, 1'b0, l9);
    check(d == 8'h39, "R8 byte after master ack", d, 8'h39);
    check(l9 == 1'b1, "R7 released in ninth clock", l9, 1);
    tx_en_i = 1'b0;
    send_byte(8'h00, 0, 0, ack);
    check(ack == 1'b0 && sda_oe == 1'b0, "R8 idle after master nack", ack, 0);
    bus_stop();

    // R9: repeated start in the middle of a byte
    r0 = n_rx; s0 = n_start;
    bus_start();
    send_byte(8'h5A, 0, 0, ack);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, 0, 0);
    bus_start();
    send_byte(8'h5A, 0, 0, ack);
    check(ack == 1'b1, "R9 address after restart", ack, 1);
    check(n_rx == r0 && n_start - s0 == 2, "R9 partial byte dropped", n_rx - r0, 0);
    bus_stop();

    // R5: busy timed against the eighth address rise
    busy_i = 1'b1;
    bus_start(); send_byte(8'h5A, 0, 2, ack); bus_stop();
    check(ack == 1'b1, "R5 busy cleared before decision", ack, 1);
    busy_i = 1'b0;
    bus_start(); send_byte(8'h5A, 2, 3, ack); bus_stop();
    check(ack == 1'b0, "R5 busy in decision cycle", ack, 0);
    bus_start(); send_byte(8'h5A, 3, 4, ack); bus_stop();
    check(ack == 1'b1, "R5 busy after decision", ack, 1);
    busy_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule